// File: doc/BRIEF.md
# Predicated Vector Reduction Engine

This block folds a run of consecutive register-file elements into one value using a symmetric two-operand operation. A per-element predicate mask selects which elements take part. The engine owns a small register file. A host loads it and reads it back through a write port and a combinational read port. The host then issues a start command with a base register, a vector length, a mask and an operation code.

The engine visits elements strictly in ascending order, one per clock, and keeps a running accumulator, so the element index and the partial result always agree. This ordering makes the engine safe for operations that wrap or carry. The final value is written into the lowest-numbered element that the mask enables, and every other element is left alone.

A pause input parks the engine between elements and exposes the next index and the partial result, as an interrupt would need. A resume input continues from that exact point. Operations whose result depends on evaluation order, and three-operand operations, are refused. Register ranges that run past the end of the file are refused as well.

Top module: `vec_reduce_engine`

## Requirements
- R1: The opcode selects the fold operation: 0 add (modulo 2^32), 1 bitwise AND, 2 bitwise OR, 3 bitwise XOR, 4 unsigned minimum, 5 unsigned maximum.
- R2: Opcode 6 (three-operand multiply-add) and opcode 7 (order-dependent subtract/divide) are refused. `illegal_o` pulses for one cycle in the cycle after the start, `busy_o` stays low and no register is written. The opcode check takes priority over the range check.
- R3: A start with a vector length of 0, a length above 16, or base + length - 1 above 31 pulses `range_err_o` in the cycle after the start. Nothing is written and `busy_o` stays low.
- R4: An accepted start with at least one enabled element raises `busy_o` for length + 1 cycles when not paused. It processes one element per cycle in ascending order, writes the result in the last busy cycle, and then pulses `done_o` for exactly one cycle.
- R5: Mask bit i enables element base + i. The result goes to the lowest enabled element. All other elements keep their values, and mask bits at or above the length are ignored.
- R6: When exactly one element is enabled, the value written is that element's own value.
- R7: When no mask bit below the length is set, no register is written, `busy_o` stays low and `done_o` pulses in the cycle after the start.
- R8: `pause_i` seen while running stops the engine before it processes another element. `paused_o` goes high, `idx_o` shows the next element offset and `acc_o` the partial result (0 if no element was enabled yet), and both hold while paused.
- R9: `resume_i` seen while paused continues from the saved index, and the final result equals that of an uninterrupted run.
- R10: Host writes are ignored while `busy_o` is high, paused included. The read port always returns the addressed entry combinationally, and all entries reset to 0.
- R11: `start_i` is ignored while `busy_o` is high; the running reduction finishes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a reduction (sampled when idle) |
| base_i | input | 5 | First register of the vector |
| vl_i | input | 5 | Vector length, 1..16 |
| mask_i | input | 16 | Predicate, bit i enables element base+i |
| op_i | input | 3 | Operation code |
| pause_i | input | 1 | Stop at the next element boundary |
| resume_i | input | 1 | Continue a paused reduction |
| wr_en_i | input | 1 | Host register write enable |
| wr_addr_i | input | 5 | Host write address |
| wr_data_i | input | 32 | Host write data |
| rd_addr_i | input | 5 | Host read address |
| rd_data_o | output | 32 | Host read data (combinational) |
| busy_o | output | 1 | Reduction in progress or paused |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle refused-opcode pulse |
| range_err_o | output | 1 | One-cycle bad-length/range pulse |
| paused_o | output | 1 | Engine is parked |
| idx_o | output | 4 | Offset of the next element to process |
| acc_o | output | 32 | Running accumulator |

## Verification
The embedded properties check several things on every cycle. They cover refusal of bad opcodes and bad ranges, the one-cycle width of `done_o`, and an idle finish for an empty mask. They also check that index and accumulator are frozen while paused, that a start arriving while busy leaves the captured parameters untouched, and that a host write during a run leaves the register file unchanged. Only the scenarios can show that the folded value is arithmetically right for each operation, including wrap-around on add. The same holds for the result landing in the lowest enabled element with its neighbours untouched, and for a paused-and-resumed run matching an uninterrupted one.

// File: rtl/vred_pkg.sv
package vred_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_MINU = 3'd4,
    OP_MAXU = 3'd5,
    OP_FMA  = 3'd6,
    OP_SUB  = 3'd7
  } red_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_PAUSE,
    ST_WRITE
  } red_state_e;

  // order-independent two-operand ops only
  function automatic logic op_legal(red_op_e op);
    return (op != OP_FMA) && (op != OP_SUB);
  endfunction
endpackage

// File: rtl/vred_alu.sv
module vred_alu
  import vred_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter bit          SIGNED_CMP = 1'b0
) (
  input  red_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   y_o
);
  logic a_lt_b;

  if (SIGNED_CMP) begin : g_cmp_s
    assign a_lt_b = $signed(a_i) < $signed(b_i);
  end else begin : g_cmp_u
    assign a_lt_b = a_i < b_i;
  end

  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_MINU: y_o = a_lt_b ? a_i : b_i;
      OP_MAXU: y_o = a_lt_b ? b_i : a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/vred_regfile.sv
module vred_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_data_i,
  input  logic          host_block_i,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [DW-1:0] eng_data_i,
  input  logic [AW-1:0] eng_raddr_i,
  output logic [DW-1:0] eng_rdata_o,
  input  logic [AW-1:0] host_raddr_i,
  output logic [DW-1:0] host_rdata_o
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NREG; e++) mem_q[e] <= '0;
    end else if (eng_we_i) begin
      mem_q[eng_addr_i] <= eng_data_i;
    end else if (host_we_i && !host_block_i) begin
      mem_q[host_addr_i] <= host_data_i;
    end
  end

  assign eng_rdata_o  = mem_q[eng_raddr_i];
  assign host_rdata_o = mem_q[host_raddr_i];

  // R10
  host_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_block_i && !(eng_we_i && eng_addr_i == host_addr_i))
      |=> mem_q[$past(host_addr_i)] == $past(mem_q[host_addr_i]));
endmodule

// File: rtl/vred_ctrl.sv
module vred_ctrl
  import vred_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned MAXVL = 16,
  localparam int unsigned AW   = $clog2(NREG),
  localparam int unsigned VLW  = $clog2(MAXVL + 1),
  localparam int unsigned IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int unsigned EW   = AW + VLW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic [MAXVL-1:0] mask_i,
  input  red_op_e          op_i,
  input  logic             pause_i,
  input  logic             resume_i,
  input  logic [DW-1:0]    elem_i,
  input  logic [DW-1:0]    alu_y_i,
  output red_op_e          op_o,
  output logic [DW-1:0]    acc_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             we_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             range_err_o,
  output logic             paused_o,
  output logic [IW-1:0]    idx_o
);
  red_state_e       state_q;
  logic [AW-1:0]    base_q;
  logic [VLW-1:0]   vl_q;
  logic [MAXVL-1:0] mask_q;
  red_op_e          op_q;
  logic [IW-1:0]    idx_q, first_q;
  logic [DW-1:0]    acc_q;
  logic             have_q, done_q, illegal_q, range_q;

  logic [MAXVL-1:0] len_mask, eff_mask;
  logic [EW-1:0]    last_addr;
  logic             range_ok, is_last;

  always_comb begin
    for (int i = 0; i < MAXVL; i++) len_mask[i] = (VLW'(i) < vl_i);
  end
  assign eff_mask  = mask_i & len_mask;
  assign last_addr = EW'(base_i) + EW'(vl_i) - EW'(1);
  assign range_ok  = (vl_i != '0) && (vl_i <= VLW'(MAXVL)) && (last_addr <= EW'(NREG - 1));
  assign is_last   = (VLW'(idx_q) == vl_q - VLW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      vl_q      <= '0;
      mask_q    <= '0;
      op_q      <= OP_ADD;
      idx_q     <= '0;
      first_q   <= '0;
      acc_q     <= '0;
      have_q    <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      range_q   <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      range_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (!op_legal(op_i))      illegal_q <= 1'b1;
          else if (!range_ok)       range_q   <= 1'b1;
          else if (eff_mask == '0)  done_q    <= 1'b1;
          else begin
            base_q  <= base_i;
            vl_q    <= vl_i;
            mask_q  <= eff_mask;
            op_q    <= op_i;
            idx_q   <= '0;
            acc_q   <= '0;
            have_q  <= 1'b0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (pause_i) begin
            state_q <= ST_PAUSE;
          end else begin
            if (mask_q[idx_q]) begin
              acc_q  <= have_q ? alu_y_i : elem_i;
              have_q <= 1'b1;
              if (!have_q) first_q <= idx_q;
            end
            if (is_last) state_q <= ST_WRITE;
            else         idx_q   <= idx_q + IW'(1);
          end
        end
        ST_PAUSE: if (resume_i) state_q <= ST_RUN;
        ST_WRITE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_o        = op_q;
  assign acc_o       = acc_q;
  assign rd_addr_o   = base_q + AW'(idx_q);
  assign we_o        = (state_q == ST_WRITE);
  assign wr_addr_o   = base_q + AW'(first_q);
  assign wr_data_o   = acc_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign paused_o    = (state_q == ST_PAUSE);
  assign done_o      = done_q;
  assign illegal_o   = illegal_q;
  assign range_err_o = range_q;
  assign idx_o       = idx_q;

  // R2
  illegal_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !op_legal(op_i)) |=> (illegal_o && !busy_o && !done_o));
  // R3
  bad_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_legal(op_i) && !range_ok) |=> (range_err_o && !busy_o && !illegal_o));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  write_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (have_q && mask_q[first_q]));
  // R7
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_legal(op_i) && range_ok && eff_mask == '0) |=> (done_o && !busy_o));
  // R8
  pause_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && pause_i) |=> (paused_o && $stable(idx_o) && $stable(acc_o)));
  // R8
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && !resume_i) |=> (paused_o && $stable(idx_o) && $stable(acc_o)));
  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(base_q) && $stable(vl_q) && $stable(mask_q) && $stable(op_q)));
endmodule

// File: rtl/vec_reduce_engine.sv
module vec_reduce_engine
  import vred_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned NREG       = 32,
  parameter int unsigned MAXVL      = 16,
  parameter bit          SIGNED_CMP = 1'b0,
  localparam int unsigned AW        = $clog2(NREG),
  localparam int unsigned VLW       = $clog2(MAXVL + 1),
  localparam int unsigned IW        = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic [MAXVL-1:0] mask_i,
  input  logic [2:0]       op_i,
  input  logic             pause_i,
  input  logic             resume_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             range_err_o,
  output logic             paused_o,
  output logic [IW-1:0]    idx_o,
  output logic [DW-1:0]    acc_o
);
  red_op_e       op_cur;
  logic [DW-1:0] elem, alu_y, eng_wdata;
  logic [AW-1:0] eng_raddr, eng_waddr;
  logic          eng_we;

  vred_ctrl #(.DW(DW), .NREG(NREG), .MAXVL(MAXVL)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_i      (base_i),
    .vl_i        (vl_i),
    .mask_i      (mask_i),
    .op_i        (red_op_e'(op_i)),
    .pause_i     (pause_i),
    .resume_i    (resume_i),
    .elem_i      (elem),
    .alu_y_i     (alu_y),
    .op_o        (op_cur),
    .acc_o       (acc_o),
    .rd_addr_o   (eng_raddr),
    .we_o        (eng_we),
    .wr_addr_o   (eng_waddr),
    .wr_data_o   (eng_wdata),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .range_err_o (range_err_o),
    .paused_o    (paused_o),
    .idx_o       (idx_o)
  );

  vred_alu #(.DW(DW), .SIGNED_CMP(SIGNED_CMP)) u_alu (
    .op_i (op_cur),
    .a_i  (acc_o),
    .b_i  (elem),
    .y_o  (alu_y)
  );

  vred_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (wr_en_i),
    .host_addr_i  (wr_addr_i),
    .host_data_i  (wr_data_i),
    .host_block_i (busy_o),
    .eng_we_i     (eng_we),
    .eng_addr_i   (eng_waddr),
    .eng_data_i   (eng_wdata),
    .eng_raddr_i  (eng_raddr),
    .eng_rdata_o  (elem),
    .host_raddr_i (rd_addr_i),
    .host_rdata_o (rd_data_o)
  );
endmodule

// File: tb/vec_reduce_engine_tb.sv
module vec_reduce_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  base_i = '0;
  logic [4:0]  vl_i = '0;
  logic [15:0] mask_i = '0;
  logic [2:0]  op_i = '0;
  logic        pause_i = 1'b0, resume_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o, acc_o;
  logic        busy_o, done_o, illegal_o, range_err_o, paused_o;
  logic [3:0]  idx_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [32];

  typedef struct {int kind; int addr; logic [31:0] val; string req;} exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  vec_reduce_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .base_i(base_i), .vl_i(vl_i),
    .mask_i(mask_i), .op_i(op_i), .pause_i(pause_i), .resume_i(resume_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o), .range_err_o(range_err_o), .paused_o(paused_o),
    .idx_o(idx_o), .acc_o(acc_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fold(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return (a < b) ? a : b;
      default: return (a < b) ? b : a;
    endcase
  endfunction

  // monitor: pops one expected item per completion pulse
  always @(negedge clk) begin
    if (rst_n && (done_o || illegal_o || range_err_o)) begin
      if (sb.size() == 0) begin
        chk("R4", "unexpected completion", 32'd1, 32'd0);
      end else begin
        exp_t e;
        int   act_kind;
        e = sb.pop_front();
        act_kind = illegal_o ? 2 : range_err_o ? 3 : ((e.kind <= 1) ? e.kind : 0);
        chk(e.req, "completion kind", act_kind, e.kind);
        if (e.kind == 0 && act_kind == 0) begin
          rd_addr_i = e.addr[4:0];
          #1;
          chk(e.req, "result value", rd_data_o, e.val);
        end
      end
    end
  end

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a[4:0]; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    model[a] = d;
  endtask

  // pause_at < 0: no pause; disturb: host write and second start while running
  task automatic reduce(input string req, input int base, input int vl, input logic [15:0] mask,
                        input int op, input int pause_at, input bit disturb);
    exp_t e;
    int first = -1, lat, cnt = 0;
    logic [31:0] acc = '0, part = '0;
    bit ok_range = (vl >= 1) && (vl <= 16) && (base + vl - 1 <= 31);
    e.req = req; e.addr = 0; e.val = '0;
    if (op >= 6) e.kind = 2;
    else if (!ok_range) e.kind = 3;
    else begin
      for (int i = 0; i < vl; i++) begin
        if (i == pause_at) part = acc;
        if (mask[i]) begin
          acc = (first < 0) ? model[base+i] : fold(op, acc, model[base+i]);
          if (first < 0) first = i;
        end
      end
      if (first < 0) e.kind = 1;
      else begin
        e.kind = 0; e.addr = base + first; e.val = acc;
        model[base+first] = acc;
      end
    end
    lat = (e.kind == 0) ? vl + 1 + ((pause_at >= 0) ? 5 : 0) : 0;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b1; base_i = base[4:0]; vl_i = vl[4:0]; mask_i = mask; op_i = op[2:0];
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      // R10 / R11: both must be ignored while busy
      wr_en_i = 1'b1; wr_addr_i = 5'(base + vl - 1); wr_data_i = 32'hDEAD_BEEF;
      start_i = 1'b1; base_i = 5'd0; vl_i = 5'd1; mask_i = 16'h1; op_i = 3'd0;
      @(negedge clk); cnt++;
      wr_en_i = 1'b0; start_i = 1'b0;
    end
    if (pause_at >= 0) begin
      repeat (pause_at - cnt) @(negedge clk);
      cnt = pause_at;
      pause_i = 1'b1;
      @(negedge clk); cnt++;
      pause_i = 1'b0;
      chk("R8", "paused_o", {31'd0, paused_o}, 32'd1);
      chk("R8", "idx_o at pause", {28'd0, idx_o}, pause_at);
      chk("R8", "acc_o at pause", acc_o, part);
      repeat (3) @(negedge clk);
      cnt += 3;
      chk("R8", "idx_o held", {28'd0, idx_o}, pause_at);
      chk("R8", "acc_o held", acc_o, part);
      chk("R10", "busy while paused", {31'd0, busy_o}, 32'd1);
      resume_i = 1'b1;
      @(negedge clk); cnt++;
      resume_i = 1'b0;
      chk("R9", "running after resume", {31'd0, paused_o}, 32'd0);
    end
    while (!(done_o || illegal_o || range_err_o) && cnt < 100) begin
      @(negedge clk); cnt++;
    end
    chk(req, "completion latency", cnt, lat);
    if (e.kind >= 2 || e.kind == 1) chk(req, "busy stays low", {31'd0, busy_o}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R4", "done is one pulse", {31'd0, done_o}, 32'd0);
    if (ok_range) begin
      for (int i = 0; i < vl; i++) begin
        rd_addr_i = 5'(base + i);
        #1;
        chk("R5", $sformatf("element %0d unaltered/result", base + i), rd_data_o, model[base+i]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "reset busy_o", {31'd0, busy_o}, 32'd0);
    chk("R4", "reset done_o", {31'd0, done_o}, 32'd0);
    chk("R8", "reset paused_o", {31'd0, paused_o}, 32'd0);
    rd_addr_i = 5'd7; #1;
    chk("R10", "reset entry value", rd_data_o, 32'd0);

    for (int i = 0; i < 32; i++) host_wr(i, (32'h1357_9BDF * (i + 1)) ^ (32'h0F0F_0000 >> (i % 8)));
    host_wr(30, 32'hFFFF_FFF0);
    host_wr(31, 32'h0000_0025);
    rd_addr_i = 5'd5; #1;
    chk("R10", "host write readback", rd_data_o, model[5]);

    reduce("R1", 0, 8, 16'h00FF, 0, -1, 1'b0);     // add
    reduce("R1", 8, 4, 16'h000F, 1, -1, 1'b0);     // and
    reduce("R1", 12, 5, 16'h001E, 2, -1, 1'b0);    // or, first enabled is element 1
    reduce("R1", 16, 6, 16'h002D, 3, -1, 1'b0);    // xor
    reduce("R1", 2, 7, 16'h0076, 4, -1, 1'b0);     // unsigned min
    reduce("R5", 20, 9, 16'h01A8, 5, -1, 1'b0);    // unsigned max, sparse mask
    reduce("R1", 30, 2, 16'h0003, 0, -1, 1'b0);    // add wraps past 2^32
    reduce("R6", 4, 4, 16'hFFF4, 0, -1, 1'b0);     // only element 2 below length
    reduce("R7", 0, 8, 16'hFF00, 0, -1, 1'b0);     // all in-range bits zero
    reduce("R2", 0, 4, 16'h000F, 6, -1, 1'b0);
    reduce("R2", 0, 20, 16'h000F, 7, -1, 1'b0);    // opcode outranks range
    reduce("R3", 20, 16, 16'hFFFF, 0, -1, 1'b0);
    reduce("R3", 0, 0, 16'hFFFF, 0, -1, 1'b0);
    reduce("R3", 0, 17, 16'hFFFF, 0, -1, 1'b0);
    reduce("R3", 31, 1, 16'h0001, 1, -1, 1'b0);    // last legal register
    reduce("R9", 6, 10, 16'h03B6, 0, 3, 1'b0);     // pause after three elements
    reduce("R9", 10, 12, 16'h0FF0, 5, 2, 1'b0);    // paused before any enabled element
    reduce("R11", 20, 8, 16'h00F3, 3, -1, 1'b1);
    reduce("R10", 1, 6, 16'h003F, 0, -1, 1'b1);

    chk("R4", "scoreboard drained", sb.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule